// File: doc/BRIEF.md
# Two-Way Multi-Channel Mailbox

This block lets two processors, called side A and side B, pass short messages to each other. Each direction has its own bank of channels. Every channel holds a 32-bit command word and a 32-bit data word. Each bank has a pending-status register and an interrupt-enable register, with one bit per channel. Both sides reach the same register file through a simple single-cycle read/write port. A sender first writes the command word and then the data word. Writing the data word marks the channel pending. An interrupt then goes to the other side, if that channel's enable bit is set. The receiver reads both words and clears the pending bit by writing a one to it. A sender must treat a channel as busy while its pending bit is set.

The A-to-B bank sits at byte offset 0x00 and drives the interrupts toward side B. The B-to-A bank follows directly after it and drives the interrupts toward side A. When both sides write in the same cycle, the rules below decide the outcome, and no message is lost.

Top module: `mbx_top`

## Requirements
- R1: Byte offsets decode on bits [7:2], and bits [1:0] are ignored. In each bank, offset +0x0 is the enable register and +0x4 is the status register. Channel c has its command word at +0x8+8c and its data word at +0xC+8c. With four channels the A-to-B bank starts at 0x00 and the B-to-A bank at 0x28. Command and data words read back exactly as last written, from either side.
- R2: A write to a command word leaves the status register unchanged.
- R3: A write to channel c's data word sets status bit c at that clock edge, so a read in the next cycle returns it.
- R4: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. Clear requests from both sides in the same cycle take effect together.
- R5: If a data-word write and a clear hit the same status bit in the same cycle, the bit ends up set.
- R6: The enable register is read/write in bits [3:0] (one bit per channel). Its upper bits read as zero.
- R7: Interrupt bit c is the AND of status bit c and enable bit c, registered, so it follows them one cycle later. It stays high until the status bit is cleared.
- R8: The A-to-B bank drives `b_irq` and the B-to-A bank drives `a_irq`.
- R9: When both sides write the same command, data or enable register in the same cycle, side A's value is stored.
- R10: Reset (synchronous, active low) zeroes every enable, status, command, data and interrupt bit.
- R11: Offsets past the second bank read zero, and writes to them change nothing. A port that is not selected returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_sel | input | 1 | Side A access this cycle |
| a_write | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 8 | Side A byte offset |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, same cycle |
| b_sel | input | 1 | Side B access this cycle |
| b_write | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 8 | Side B byte offset |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, same cycle |
| a_irq | output | 4 | Per-channel interrupts toward side A (B-to-A bank) |
| b_irq | output | 4 | Per-channel interrupts toward side B (A-to-B bank) |

## Verification
The bench builds the block with its defaults: four channels, 32-bit words and an 8-bit offset. This places both banks within 0x00–0x4C and leaves 0x50–0xFF unmapped, so random offsets regularly hit the unmapped space, both banks, and misaligned low bits. Both ports are driven at the same time, so random traffic repeatedly produces same-register write collisions and data writes coinciding with clears on one status bit. Directed steps pin down the exact cycle at which status and interrupt bits rise and fall.

// File: rtl/mbx_pkg.sv
// Shared types for the mailbox: the register kinds an offset can decode to.
package mbx_pkg;
    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_IEN  = 3'd1,
        K_STAT = 3'd2,
        K_CMD  = 3'd3,
        K_DAT  = 3'd4
    } reg_kind_e;
endpackage

// File: rtl/mbx_port_dec.sv
// Address decoder for one access port.
// Maps a byte offset to a bank, register kind and channel. Assumes the two
// banks sit back to back from offset 0 and that 2*BANK_WORDS fits the word index.
module mbx_port_dec #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]       addr,
    output logic                    hit,
    output logic                    bank,
    output mbx_pkg::reg_kind_e      kind,
    output logic [$clog2(NCH)-1:0]  ch
);
    localparam int WA = ADDR_W - 2;
    localparam int CH_W = $clog2(NCH);
    localparam logic [WA-1:0] BANK_WORDS = WA'(2 + 2 * NCH);
    localparam logic [WA-1:0] ALL_WORDS  = WA'(2 * (2 + 2 * NCH));

    logic [WA-1:0] word;
    logic [WA-1:0] local_w;
    logic [WA-1:0] slot;

    // Split the word index into bank, register kind and channel.
    always_comb begin
        word    = addr[ADDR_W-1:2];
        hit     = 1'b0;
        bank    = 1'b0;
        local_w = '0;
        kind    = mbx_pkg::K_NONE;
        ch      = '0;
        slot    = '0;
        if (word < BANK_WORDS) begin
            hit     = 1'b1;
            local_w = word;
        end else if (word < ALL_WORDS) begin
            hit     = 1'b1;
            bank    = 1'b1;
            local_w = word - BANK_WORDS;
        end
        if (hit) begin
            if (local_w == WA'(0)) begin
                kind = mbx_pkg::K_IEN;
            end else if (local_w == WA'(1)) begin
                kind = mbx_pkg::K_STAT;
            end else begin
                slot = local_w - WA'(2);
                ch   = CH_W'(slot >> 1);
                kind = slot[0] ? mbx_pkg::K_DAT : mbx_pkg::K_CMD;
            end
        end
    end
endmodule

// File: rtl/mbx_bank.sv
// One directional mailbox bank: enable, pending status, command/data words, irqs.
// Both ports may write in the same cycle: port 0 (side A) wins on ordinary
// registers, status clears combine, and a data-word set beats a clear.
// Assumes wr[p] is only raised for accesses that decode into this bank.
module mbx_bank #(
    parameter int NCH = 4,
    parameter int DW  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                wr,
    input  logic [1:0]                rd,
    input  mbx_pkg::reg_kind_e        kind  [2],
    input  logic [$clog2(NCH)-1:0]    ch    [2],
    input  logic [DW-1:0]             wdata [2],
    output logic [DW-1:0]             rdata [2],
    output logic [NCH-1:0]            stat_o,
    output logic [NCH-1:0]            ien_o,
    output logic [NCH-1:0]            set_o,
    output logic [NCH-1:0]            clr_o,
    output logic [NCH-1:0]            irq_o
);
    localparam int CH_W = $clog2(NCH);

    logic [DW-1:0]  cmd_q [NCH];
    logic [DW-1:0]  dat_q [NCH];
    logic [NCH-1:0] stat_q, ien_q, irq_q;
    logic [NCH-1:0] set_v, clr_v;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [1:0] cmd_hit, dat_hit;
        for (genvar p = 0; p < 2; p++) begin : g_port
            assign cmd_hit[p] = wr[p] && (kind[p] == mbx_pkg::K_CMD) && (ch[p] == CH_W'(c));
            assign dat_hit[p] = wr[p] && (kind[p] == mbx_pkg::K_DAT) && (ch[p] == CH_W'(c));
        end
        assign set_v[c] = |dat_hit;

        // Command word storage, side A beating side B.
        always_ff @(posedge clk) begin
            if (!rst_n)          cmd_q[c] <= '0;
            else if (cmd_hit[0]) cmd_q[c] <= wdata[0];
            else if (cmd_hit[1]) cmd_q[c] <= wdata[1];
        end

        // Data word storage, side A beating side B.
        always_ff @(posedge clk) begin
            if (!rst_n)          dat_q[c] <= '0;
            else if (dat_hit[0]) dat_q[c] <= wdata[0];
            else if (dat_hit[1]) dat_q[c] <= wdata[1];
        end
    end

    // Gather write-one-to-clear requests from both ports.
    always_comb begin
        clr_v = '0;
        for (int p = 0; p < 2; p++) begin
            if (wr[p] && (kind[p] == mbx_pkg::K_STAT)) clr_v = clr_v | wdata[p][NCH-1:0];
        end
    end

    // Pending status: clear first, then set, so a same-cycle set survives.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_v) | set_v;
    end

    // Interrupt enable register, side A beating side B.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_q <= '0;
        else if (wr[0] && (kind[0] == mbx_pkg::K_IEN))
            ien_q <= wdata[0][NCH-1:0];
        else if (wr[1] && (kind[1] == mbx_pkg::K_IEN))
            ien_q <= wdata[1][NCH-1:0];
    end

    // Registered per-channel interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= stat_q & ien_q;
    end

    // Per-port read mux; zero when the port is not reading this bank.
    always_comb begin
        for (int p = 0; p < 2; p++) begin
            rdata[p] = '0;
            if (rd[p]) begin
                case (kind[p])
                    mbx_pkg::K_IEN:  rdata[p][NCH-1:0] = ien_q;
                    mbx_pkg::K_STAT: rdata[p][NCH-1:0] = stat_q;
                    mbx_pkg::K_CMD:  rdata[p] = cmd_q[ch[p]];
                    mbx_pkg::K_DAT:  rdata[p] = dat_q[ch[p]];
                    default:         rdata[p] = '0;
                endcase
            end
        end
    end

    assign stat_o = stat_q;
    assign ien_o  = ien_q;
    assign set_o  = set_v;
    assign clr_o  = clr_v;
    assign irq_o  = irq_q;
endmodule

// File: rtl/mbx_top.sv
// Two-way mailbox top: two access ports sharing one register file of two banks.
// Bank 0 carries A-to-B traffic and interrupts side B; bank 1 carries B-to-A
// traffic and interrupts side A. Reads are combinational within the access cycle.
module mbx_top #(
    parameter int NCH    = 4,
    parameter int DW     = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_sel,
    input  logic              a_write,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DW-1:0]     a_wdata,
    output logic [DW-1:0]     a_rdata,
    input  logic              b_sel,
    input  logic              b_write,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DW-1:0]     b_wdata,
    output logic [DW-1:0]     b_rdata,
    output logic [NCH-1:0]    a_irq,
    output logic [NCH-1:0]    b_irq
);
    localparam int CH_W = $clog2(NCH);

    logic [1:0]          p_sel, p_write, p_hit, p_bank;
    logic [ADDR_W-1:0]   p_addr  [2];
    logic [DW-1:0]       p_wdata [2];
    mbx_pkg::reg_kind_e  p_kind  [2];
    logic [CH_W-1:0]     p_ch    [2];

    logic [1:0][NCH-1:0] stat_all, ien_all, set_all, clr_all, irq_all;

    assign p_sel   = {b_sel, a_sel};
    assign p_write = {b_write, a_write};
    assign p_addr[0]  = a_addr;
    assign p_addr[1]  = b_addr;
    assign p_wdata[0] = a_wdata;
    assign p_wdata[1] = b_wdata;

    for (genvar p = 0; p < 2; p++) begin : g_dec
        mbx_port_dec #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
            .addr (p_addr[p]),
            .hit  (p_hit[p]),
            .bank (p_bank[p]),
            .kind (p_kind[p]),
            .ch   (p_ch[p])
        );
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [1:0]    wr, rd;
        logic [DW-1:0] rd_w [2];

        // Route each port's access to this bank when its offset lands here.
        always_comb begin
            for (int p = 0; p < 2; p++) begin
                wr[p] = p_sel[p] && p_write[p]  && p_hit[p] && (p_bank[p] == 1'(g));
                rd[p] = p_sel[p] && !p_write[p] && p_hit[p] && (p_bank[p] == 1'(g));
            end
        end

        mbx_bank #(.NCH(NCH), .DW(DW)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (wr),
            .rd     (rd),
            .kind   (p_kind),
            .ch     (p_ch),
            .wdata  (p_wdata),
            .rdata  (rd_w),
            .stat_o (stat_all[g]),
            .ien_o  (ien_all[g]),
            .set_o  (set_all[g]),
            .clr_o  (clr_all[g]),
            .irq_o  (irq_all[g])
        );
    end

    // Merge bank read data; at most one bank drives non-zero per port.
    always_comb begin
        a_rdata = g_bank[0].rd_w[0] | g_bank[1].rd_w[0];
        b_rdata = g_bank[0].rd_w[1] | g_bank[1].rd_w[1];
    end

    assign b_irq = irq_all[0];
    assign a_irq = irq_all[1];
endmodule

// File: rtl/mbx_checker.sv
// Property checker for mbx_top, attached by bind. Watches bank status, enable,
// set and clear vectors and the interrupt outputs.
module mbx_checker #(
    parameter int NCH = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0][NCH-1:0] stat,
    input logic [1:0][NCH-1:0] ien,
    input logic [1:0][NCH-1:0] set,
    input logic [1:0][NCH-1:0] clr,
    input logic [NCH-1:0]      a_irq,
    input logic [NCH-1:0]      b_irq
);
    assert_reset_zero_R10: assert property (@(posedge clk)
        !rst_n |=> (stat == '0 && ien == '0 && a_irq == '0 && b_irq == '0));

    assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((stat & $past(set)) == $past(set)));

    assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((set & clr) != '0) |=> ((stat & $past(set & clr)) == $past(set & clr)));

    assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~set) != '0) |=> ((stat & $past(clr & ~set)) == '0));

    assert_no_stray_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat & ~$past(stat) & ~$past(set)) == '0);

    // R7 and R8: an interrupt needs the matching bank's pending and enable bits one cycle before.
    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ({a_irq, b_irq} & ~($past(stat) & $past(ien))) == '0);
endmodule

bind mbx_top mbx_checker #(.NCH(NCH)) u_mbx_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .stat  (stat_all),
    .ien   (ien_all),
    .set   (set_all),
    .clr   (clr_all),
    .a_irq (a_irq),
    .b_irq (b_irq)
);

// File: tb/tb_mbx_top.sv
`timescale 1ns/100ps
module tb_mbx_top;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_sel = 0, a_write = 0, b_sel = 0, b_write = 0;
    logic [7:0]  a_addr = 0, b_addr = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0;
    logic [31:0] a_rdata, b_rdata;
    logic [3:0]  a_irq, b_irq;

    always #2.5 clk = ~clk;

    mbx_top #(.NCH(NCH), .DW(32), .ADDR_W(8)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_sel(a_sel), .a_write(a_write), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_sel(b_sel), .b_write(b_write), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .a_irq(a_irq), .b_irq(b_irq)
    );

    int unsigned nvec = 0, nbad = 0;
    bit done = 0;

    logic [31:0] m_cmd [2][4];
    logic [31:0] m_dat [2][4];
    logic [3:0]  m_ien [2];
    logic [3:0]  m_stat [2];
    logic [3:0]  t_clr [2];
    logic [3:0]  t_set [2];
    logic [31:0] ra, rb;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // Offset decode written from R1: words of 10 per bank, enable, status, then cmd/data pairs.
    function automatic void bdec(input logic [7:0] a, output int bank, output int kind, output int ch);
        int w = int'(a) / 4;
        bank = -1; kind = 0; ch = 0;
        if (w < 10) bank = 0;
        else if (w < 20) begin bank = 1; w = w - 10; end
        if (bank >= 0) begin
            if (w == 0) kind = 1;
            else if (w == 1) kind = 2;
            else begin ch = (w - 2) / 2; kind = ((w - 2) % 2 == 1) ? 4 : 3; end
        end
    endfunction

    function automatic logic [31:0] mread(input logic [7:0] a);
        int bk, kd, c;
        bdec(a, bk, kd, c);
        case (kd)
            1: return {28'd0, m_ien[bk]};
            2: return {28'd0, m_stat[bk]};
            3: return m_cmd[bk][c];
            4: return m_dat[bk][c];
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rtag(input logic [7:0] a);
        int bk, kd, c;
        bdec(a, bk, kd, c);
        case (kd)
            1: return "R6 enable read";
            2: return "R4 status read";
            3, 4: return "R1 word read";
            default: return "R11 unmapped read";
        endcase
    endfunction

    function automatic void apply1(input bit en, input bit wr, input logic [7:0] a, input logic [31:0] d);
        int bk, kd, c;
        if (!(en && wr)) return;
        bdec(a, bk, kd, c);
        case (kd)
            1: m_ien[bk] = d[3:0];
            2: t_clr[bk] = t_clr[bk] | d[3:0];
            3: m_cmd[bk][c] = d;
            4: begin m_dat[bk][c] = d; t_set[bk][c] = 1'b1; end
            default: ;
        endcase
    endfunction

    // One access cycle on both ports; R9: side B applied first so side A overwrites.
    task automatic cyc(input bit ae, input bit aw, input logic [7:0] aa, input logic [31:0] ad,
                       input bit be, input bit bw, input logic [7:0] ba, input logic [31:0] bd);
        logic [3:0] pre0, pre1;
        @(negedge clk);
        a_sel = ae; a_write = aw; a_addr = aa; a_wdata = ad;
        b_sel = be; b_write = bw; b_addr = ba; b_wdata = bd;
        #1;
        ra = a_rdata; rb = b_rdata;
        chk((ae && !aw) ? rtag(aa) : "R11 idle read", ra, (ae && !aw) ? mread(aa) : 32'd0);
        chk((be && !bw) ? rtag(ba) : "R11 idle read", rb, (be && !bw) ? mread(ba) : 32'd0);
        pre0 = m_stat[0] & m_ien[0];
        pre1 = m_stat[1] & m_ien[1];
        for (int k = 0; k < 2; k++) begin t_clr[k] = '0; t_set[k] = '0; end
        apply1(be, bw, ba, bd);
        apply1(ae, aw, aa, ad);
        for (int k = 0; k < 2; k++) m_stat[k] = (m_stat[k] & ~t_clr[k]) | t_set[k];
        @(posedge clk); #1;
        chk("R7 R8 a_irq", {28'd0, a_irq}, {28'd0, pre1});
        chk("R7 R8 b_irq", {28'd0, b_irq}, {28'd0, pre0});
    endtask

    task automatic idle();
        cyc(0, 0, 8'h0, 32'h0, 0, 0, 8'h0, 32'h0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_2024));
        for (int k = 0; k < 2; k++) begin
            m_ien[k] = '0; m_stat[k] = '0;
            for (int c = 0; c < 4; c++) begin m_cmd[k][c] = '0; m_dat[k][c] = '0; end
        end
        repeat (3) @(posedge clk);
        #1;
        chk("R10 a_irq after reset", {28'd0, a_irq}, 32'd0);
        chk("R10 b_irq after reset", {28'd0, b_irq}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R10: registers read zero after reset
        cyc(1, 0, 8'h04, 0, 1, 0, 8'h2C, 0);
        chk("R10 status A2B", ra, 32'd0);
        chk("R10 status B2A", rb, 32'd0);
        cyc(1, 0, 8'h0C, 0, 1, 0, 8'h30, 0);
        chk("R10 data word", ra, 32'd0);
        chk("R10 cmd word", rb, 32'd0);

        // R2: command write alone does not set status
        cyc(1, 1, 8'h10, 32'h0000_0011, 0, 0, 8'h0, 0);
        cyc(1, 0, 8'h10, 0, 1, 0, 8'h04, 0);
        chk("R1 cmd readback", ra, 32'h0000_0011);
        chk("R2 status after cmd", rb, 32'd0);

        // R3: data write sets status at that edge
        cyc(1, 1, 8'h14, 32'h0000_0022, 0, 0, 8'h0, 0);
        cyc(0, 0, 8'h0, 0, 1, 0, 8'h04, 0);
        chk("R3 status after data", rb, 32'h2);

        // R8/R7: enable on A2B bank raises b_irq only, one cycle after enable lands
        cyc(0, 0, 8'h0, 0, 1, 1, 8'h00, 32'hF);
        chk("R7 irq not yet", {28'd0, b_irq}, 32'd0);
        idle();
        chk("R8 b_irq channel 1", {28'd0, b_irq}, 32'h2);
        chk("R8 a_irq quiet", {28'd0, a_irq}, 32'd0);

        // R4: writing zeros keeps, writing one clears
        cyc(0, 0, 8'h0, 0, 1, 1, 8'h04, 32'h0);
        cyc(0, 0, 8'h0, 0, 1, 0, 8'h04, 0);
        chk("R4 zero write keeps", rb, 32'h2);
        cyc(0, 0, 8'h0, 0, 1, 1, 8'h05, 32'h2);
        chk("R7 irq held until clear seen", {28'd0, b_irq}, 32'h2);
        idle();
        chk("R7 irq drops after clear", {28'd0, b_irq}, 32'd0);
        cyc(0, 0, 8'h0, 0, 1, 0, 8'h04, 0);
        chk("R4 one clears", rb, 32'd0);

        // R5: set and clear on same bit in same cycle
        cyc(1, 1, 8'h1C, 32'h0000_0033, 1, 1, 8'h04, 32'h4);
        cyc(0, 0, 8'h0, 0, 1, 0, 8'h04, 0);
        chk("R5 set wins", rb, 32'h4);

        // R9: both sides write the same command word
        cyc(1, 1, 8'h30, 32'hAAAA_0001, 1, 1, 8'h30, 32'hBBBB_0002);
        cyc(1, 0, 8'h30, 0, 0, 0, 8'h0, 0);
        chk("R9 side A wins", ra, 32'hAAAA_0001);

        // R11: unmapped offset
        cyc(1, 1, 8'h50, 32'hFFFF_FFFF, 0, 0, 8'h0, 0);
        cyc(1, 0, 8'h50, 0, 1, 0, 8'h04, 0);
        chk("R11 unmapped reads zero", ra, 32'd0);
        chk("R11 status untouched", rb, 32'h4);

        // R6: enable upper bits read zero
        cyc(1, 1, 8'h28, 32'hFFFF_FFFF, 0, 0, 8'h0, 0);
        cyc(1, 0, 8'h28, 0, 0, 0, 8'h0, 0);
        chk("R6 enable width", ra, 32'hF);

        // Random traffic on both ports, checked against the model.
        for (int i = 0; i < 6000; i++) begin
            logic [7:0] aa, ba;
            aa = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'({$urandom_range(0, 21), 2'($urandom)});
            ba = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'({$urandom_range(0, 21), 2'($urandom)});
            cyc(1'($urandom_range(0, 3) != 0), 1'($urandom), aa,
                ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 15)) : $urandom,
                1'($urandom_range(0, 3) != 0), 1'($urandom), ba,
                ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 15)) : $urandom);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule